// File: doc/BRIEF.md
# Serial-Port SAR Converter Emulator

This block is the digital side of a two-input, 12-bit successive-approximation converter with a four-wire serial port. It is meant as a synthesizable stand-in for the converter: a host drives the conversion-start, serial clock and serial data lines just as it would drive the real device. A parallel stimulus port supplies the 12-bit code that the selected input pair would have produced. The block times the conversion in system-clock cycles and latches the stimulus when the timer runs out. It formats the code for the polarity mode that was in force when the conversion began, then shifts it out MSB first. While the result leaves, it collects a 6-bit configuration word that applies to the following conversion.

All pins are taken to be synchronous to the system clock. Edges are found by comparing each pin with its value one clock earlier. The output-enable, the sleep flag and the decoded input-pair code are brought out, so that a pad ring or a loopback harness can use them directly.

The stimulus is read as an offset-binary code, where 0 is the most negative input and all ones is the most positive.

Top module: `adc_serial_emu`

## Requirements
- R1: A conversion-start rising edge seen while the block is idle starts a conversion. The conversion lasts exactly CONV_CYCLES clock edges, counted from the edge that detects the rise. Further rising edges during the conversion neither restart it nor lengthen it.
- R2: `sdo_oe` is 0 whenever `cnv_pin` is 1 and throughout a conversion. It is 1 when the block is idle with `cnv_pin` at 0.
- R3: If `cnv_pin` is 1 on the edge where the timer expires, `asleep` becomes 1 and stays 1 while `cnv_pin` stays 1. On the first edge after `cnv_pin` falls, `asleep` clears, `sdo_oe` becomes 1 and `sdo_pin` shows the MSB.
- R4: If `cnv_pin` is 0 on the edge where the timer expires, the MSB appears on `sdo_pin` with `sdo_oe` at 1 on that edge, and `asleep` stays 0. This includes the case where `cnv_pin` falls exactly on that edge.
- R5: The result leaves MSB first, one bit per `sck_pin` falling edge. After the 11th falling edge the LSB stays on `sdo_pin`, and further falling edges change nothing.
- R6: The first six `sck_pin` rising edges of a transfer capture `sdi_pin`. Bit order is: single-ended flag, odd flag, two ignored bits, unipolar flag, one ignored bit. The word takes effect at the next conversion start. A transfer with fewer than six rising edges leaves the configuration unchanged. Rising edges after the sixth are ignored.
- R7: `pair_sel` gives {single-ended, odd} of the conversion in progress or just finished: 00 = CH0 positive, CH1 negative; 01 = CH1 positive, CH0 negative; 10 = CH0 against ground; 11 = CH1 against ground.
- R8: With the unipolar flag at 1 the result equals the stimulus. With it at 0 the result is two's complement, which means the stimulus with its MSB inverted: 0x800 gives 0x000, 0x000 gives 0x800, 0xFFF gives 0x7FF.
- R9: After reset the configuration is all zeros (pair 00, bipolar), `asleep` is 0, the output latch holds 0, and `sdo_oe` is 1 while `cnv_pin` is 0.
- R10: `sck_pin` edges while `cnv_pin` is 1 shift no data and capture no configuration bits.
- R11: No conversion stays in progress for CONV_MAX_CYCLES clock edges or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_pin | input | 1 | Conversion-start line |
| sck_pin | input | 1 | Serial clock from the host |
| sdi_pin | input | 1 | Serial configuration data from the host |
| sample_i | input | DATA_W | Offset-binary stimulus code for the selected pair |
| sdo_pin | output | 1 | Serial result bit |
| sdo_oe | output | 1 | Drive enable for the serial result (0 = high impedance) |
| asleep | output | 1 | Block is in the sleep state |
| pair_sel | output | 2 | Decoded input-pair code of the current conversion |

## Verification
The sharpest collision is the timer expiring on the same clock edge where conversion-start falls. The block must then go straight to the awake, driving state and never touch sleep. The bench holds conversion-start high from the start edge and drops it half a cycle before the expiry edge. It checks that `asleep` stays 0 and the MSB is driven right after that edge. A second run drops the line one cycle later and expects one cycle of sleep instead. A conversion-start rise that lands mid-conversion is also raised against the running timer; it is judged by the output enable rising on exactly the original expiry edge.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    // Control states of the converter emulator
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2
    } conv_state_e;

    // Input pair selection, encoded as {single_ended, odd}
    typedef enum logic [1:0] {
        PAIR_CH0P_CH1N = 2'b00,
        PAIR_CH1P_CH0N = 2'b01,
        PAIR_CH0_GND   = 2'b10,
        PAIR_CH1_GND   = 2'b11
    } pair_sel_e;

    typedef struct packed {
        logic single_ended;
        logic odd_sel;
        logic unipolar;
    } conv_cfg_t;

    // Serial configuration word layout (first bit received lands at the top)
    localparam int CFG_WORD_W = 6;
    localparam int SE_BIT     = 5;
    localparam int ODD_BIT    = 4;
    localparam int UNI_BIT    = 1;

    // Pin positions inside the edge sampler vector
    localparam int PIN_CNV   = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_COUNT = 2;

    function automatic conv_cfg_t unpack_cfg(input logic [CFG_WORD_W-1:0] w);
        conv_cfg_t c;
        c.single_ended = w[SE_BIT];
        c.odd_sel      = w[ODD_BIT];
        c.unipolar     = w[UNI_BIT];
        return c;
    endfunction

    function automatic pair_sel_e pair_of(input conv_cfg_t c);
        return pair_sel_e'({c.single_ended, c.odd_sel});
    endfunction

endpackage

// File: rtl/adc_pin_sampler.sv
module adc_pin_sampler #(
    parameter int N_PINS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] rise_o,
    output logic [N_PINS-1:0] fall_o
);

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_pin
            logic prev_q;

            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= pin_i[g];
            end

            assign rise_o[g] = pin_i[g] & ~prev_q;
            assign fall_o[g] = ~pin_i[g] & prev_q;
        end
    endgenerate

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_emu_pkg::*;
#(
    parameter int CONV_CYCLES     = 130,
    parameter int CONV_MAX_CYCLES = 160
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cnv_level_i,
    input  logic        cnv_rise_i,
    input  logic        cnv_fall_i,
    input  conv_cfg_t   cfg_next_i,
    output conv_state_e state_o,
    output logic        start_o,
    output logic        done_o,
    output conv_cfg_t   active_cfg_o
);

    localparam int TMR_W = $clog2(CONV_CYCLES + 1);
    localparam int AGE_W = $clog2(CONV_MAX_CYCLES + 2);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(CONV_CYCLES - 1);
    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(CONV_MAX_CYCLES);

    conv_state_e      st_q, st_d;
    logic [TMR_W-1:0] tmr_q;
    conv_cfg_t        active_q;
    logic [AGE_W-1:0] age_q;

    assign start_o      = (st_q == ST_READY) && cnv_rise_i;
    assign done_o       = (st_q == ST_CONV) && (tmr_q == '0);
    assign state_o      = st_q;
    assign active_cfg_o = active_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY: if (start_o) st_d = ST_CONV;
            ST_CONV:  if (done_o)  st_d = cnv_level_i ? ST_SLEEP : ST_READY;
            ST_SLEEP: if (cnv_fall_i) st_d = ST_READY;
            default:  st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_READY;
            tmr_q    <= '0;
            active_q <= '0;
        end else begin
            st_q <= st_d;
            if (start_o) begin
                tmr_q    <= TMR_LOAD;
                active_q <= cfg_next_i;
            end else if ((st_q == ST_CONV) && (tmr_q != '0)) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    // Independent age counter, used only to bound the conversion length
    always_ff @(posedge clk) begin
        if (rst)                                    age_q <= '0;
        else if (start_o)                           age_q <= '0;
        else if ((st_q == ST_CONV) && (age_q != AGE_MAX)) age_q <= age_q + 1'b1;
    end

    // R1
    conv_restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV && tmr_q != '0) |=> (st_q == ST_CONV && tmr_q == $past(tmr_q) - 1'b1));

    // R11
    conv_len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CONV) |-> (age_q < AGE_MAX));

    // R3
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP && cnv_level_i) |=> (st_q == ST_SLEEP));

    // R4
    awake_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cnv_level_i) |=> (st_q == ST_READY));

endmodule

// File: rtl/adc_cfg_port.sv
module adc_cfg_port #(
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             cap_en_i,
    input  logic             sck_rise_i,
    input  logic             sdi_i,
    output logic [CFG_W-1:0] cfg_word_o
);

    localparam int CNT_W = $clog2(CFG_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CFG_W - 1);

    logic [CFG_W-2:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CFG_W-1:0] word_q;
    logic [CFG_W-1:0] assembled;
    logic             take;

    assign assembled  = {sh_q, sdi_i};
    assign take       = cap_en_i && sck_rise_i && (cnt_q < CNT_FULL);
    assign cfg_word_o = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            word_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (take) begin
            sh_q  <= assembled[CFG_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) word_q <= assembled;
        end
    end

    // R6
    cfg_full_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_FULL && !clear_i) |=> $stable(word_q));

    // R10
    cfg_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en_i) |=> $stable(word_q) && $stable(sh_q));

endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              unipolar_i,
    input  logic              shift_en_i,
    input  logic              sck_fall_i,
    output logic              sdo_o
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] fmt_w;
    logic [CNT_W-1:0]  cnt_q;
    logic              step;

    // Offset binary to two's complement is an MSB inversion
    always_comb begin
        fmt_w = sample_i;
        if (!unipolar_i) fmt_w[DATA_W-1] = ~sample_i[DATA_W-1];
    end

    assign step  = shift_en_i && sck_fall_i && (cnt_q != CNT_LAST);
    assign sdo_o = sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            sh_q  <= fmt_w;
            cnt_q <= '0;
        end else if (step) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    last_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_LAST && !load_i) |=> $stable(sh_q));

    // R5
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load_i) |=> (sdo_o == $past(sh_q[DATA_W-2])));

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W          = 12,
    parameter int CONV_CYCLES     = 130,
    parameter int CONV_MAX_CYCLES = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_pin,
    input  logic              sck_pin,
    input  logic              sdi_pin,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_pin,
    output logic              sdo_oe,
    output logic              asleep,
    output logic [1:0]        pair_sel
);

    logic [PIN_COUNT-1:0] pin_vec, rise_vec, fall_vec;
    conv_state_e          state;
    logic                 conv_start, conv_done, xfer_en;
    conv_cfg_t            active_cfg, cfg_next;
    logic [CFG_WORD_W-1:0] cfg_word;

    assign pin_vec[PIN_CNV] = cnv_pin;
    assign pin_vec[PIN_SCK] = sck_pin;

    adc_pin_sampler #(.N_PINS(PIN_COUNT)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_vec),
        .rise_o (rise_vec),
        .fall_o (fall_vec)
    );

    assign cfg_next = unpack_cfg(cfg_word);

    adc_conv_ctrl #(
        .CONV_CYCLES     (CONV_CYCLES),
        .CONV_MAX_CYCLES (CONV_MAX_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cnv_level_i  (cnv_pin),
        .cnv_rise_i   (rise_vec[PIN_CNV]),
        .cnv_fall_i   (fall_vec[PIN_CNV]),
        .cfg_next_i   (cfg_next),
        .state_o      (state),
        .start_o      (conv_start),
        .done_o       (conv_done),
        .active_cfg_o (active_cfg)
    );

    // Transfer window: result latched and conversion-start held low
    assign xfer_en = (state == ST_READY) && !cnv_pin;

    adc_cfg_port #(.CFG_W(CFG_WORD_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (conv_start),
        .cap_en_i   (xfer_en),
        .sck_rise_i (rise_vec[PIN_SCK]),
        .sdi_i      (sdi_pin),
        .cfg_word_o (cfg_word)
    );

    adc_out_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (conv_done),
        .sample_i   (sample_i),
        .unipolar_i (active_cfg.unipolar),
        .shift_en_i (xfer_en),
        .sck_fall_i (fall_vec[PIN_SCK]),
        .sdo_o      (sdo_pin)
    );

    assign sdo_oe   = xfer_en;
    assign asleep   = (state == ST_SLEEP);
    assign pair_sel = pair_of(active_cfg);

endmodule

// File: tb/adc_serial_emu_tb.sv
module adc_serial_emu_tb;

    localparam int DW = 12;
    localparam int N  = 130;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [DW-1:0] sample = '0;
    logic sdo, oe, slp;
    logic [1:0] pair;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Bench model of the configuration pipeline
    logic [1:0]    pend_pair = 2'b00;
    logic          pend_uni  = 1'b0;
    logic [1:0]    act_pair  = 2'b00;
    logic [DW-1:0] exp_word  = '0;

    adc_serial_emu #(.DATA_W(DW), .CONV_CYCLES(N), .CONV_MAX_CYCLES(160)) u_dut (
        .clk(clk), .rst(rst), .cnv_pin(cnv), .sck_pin(sck), .sdi_pin(sdi),
        .sample_i(sample), .sdo_pin(sdo), .sdo_oe(oe), .asleep(slp), .pair_sel(pair)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fmt(input logic [DW-1:0] s, input logic uni);
        return uni ? s : (s ^ {1'b1, {(DW-1){1'b0}}});
    endfunction

    // Latch the pending configuration as the bench expects at a conversion start
    task automatic arm(input logic [DW-1:0] s);
        sample   = s;
        act_pair = pend_pair;
        exp_word = fmt(s, pend_uni);
    endtask

    task automatic sck_pulse(input logic d);
        sdi = d;
        @(negedge clk) sck = 1'b1;
        @(negedge clk) sck = 1'b0;
        @(posedge clk) #1;
    endtask

    // Short pulse on conversion-start, timer boundary checked on both sides
    task automatic run_conv(input logic [DW-1:0] s);
        arm(s);
        @(negedge clk) cnv = 1'b1;
        @(negedge clk) cnv = 1'b0;
        repeat (N - 1) @(posedge clk);
        #1;
        chk("R1 still converting one edge before expiry (oe)", oe, 0);
        chk("R2 no drive during conversion", oe, 0);
        @(posedge clk) #1;
        chk("R4 drive at expiry", oe, 1);
        chk("R4 awake at expiry", slp, 0);
        chk("R4 MSB at expiry", sdo, exp_word[DW-1]);
        chk("R7 pair code", pair, act_pair);
    endtask

    // Full 12-clock readout, stream[11:6] is the configuration word
    task automatic read_word(input logic [DW-1:0] stream, input string tag);
        logic [DW-1:0] got;
        for (int i = 0; i < DW; i++) begin
            got[DW-1-i] = sdo;
            sck_pulse(stream[DW-1-i]);
        end
        chk({tag, " R5/R8 word"}, got, exp_word);
        chk("R5 LSB held after last edge", sdo, exp_word[0]);
        sck_pulse(1'b1);
        chk("R5 extra fall ignored", sdo, exp_word[0]);
        pend_pair = stream[DW-1 -: 2];
        pend_uni  = stream[DW-5];
    endtask

    task automatic t_reset();
        chk("R9 reset asleep", slp, 0);
        chk("R9 reset pair", pair, 0);
        chk("R9 reset oe", oe, 1);
        chk("R9 reset sdo", sdo, 0);
    endtask

    task automatic t_basic();
        run_conv(12'hC35);
        read_word({6'b000010, 6'b101010}, "R8 bipolar basic");
    endtask

    task automatic t_pairs();
        run_conv(12'hABC);
        read_word({6'b110000, 6'b000000}, "R8 unipolar");
        run_conv(12'h800);
        read_word({6'b100010, 6'b000000}, "R8 bipolar zero");
        run_conv(12'hFFF);
        read_word({6'b010000, 6'b000000}, "R8 unipolar full");
        run_conv(12'h000);
        read_word({6'b000000, 6'b111111}, "R6 trailing rises ignored");
        run_conv(12'hFFF);
        read_word({6'b000010, 6'b000000}, "R8 bipolar top");
    endtask

    task automatic t_partial();
        // Only three rising edges: configuration must not change (R6)
        sck_pulse(1'b1);
        sck_pulse(1'b1);
        sck_pulse(1'b0);
        run_conv(12'h123);
        chk("R6 partial word kept pair", pair, 2'b00);
        // finish the readout of the remaining bits only through a fresh word
        read_word_tail();
    endtask

    task automatic read_word_tail();
        // Drain by starting nothing; result already checked via MSB. Reconfigure bipolar pair 00.
        for (int i = 0; i < DW; i++) sck_pulse(1'b0);
        pend_pair = 2'b00;
        pend_uni  = 1'b0;
        chk("R5 LSB after drain", sdo, exp_word[0]);
    endtask

    task automatic t_sleep();
        arm(12'h5A5);
        @(negedge clk) cnv = 1'b1;
        repeat (N + 3) @(posedge clk);
        #1;
        chk("R3 asleep", slp, 1);
        chk("R2 no drive while high", oe, 0);
        for (int i = 0; i < 8; i++) sck_pulse(1'b1);
        chk("R3 still asleep", slp, 1);
        @(negedge clk) cnv = 1'b0;
        @(posedge clk) #1;
        chk("R3 wake", slp, 0);
        chk("R3 drive on wake", oe, 1);
        chk("R3 MSB on wake", sdo, exp_word[DW-1]);
        read_word({6'b100010, 6'b000000}, "R10 edges while high");
        run_conv(12'h3C3);
        chk("R10 config from high window not taken", pair, 2'b10);
        read_word({6'b000000, 6'b000000}, "R8 after sleep");
    endtask

    task automatic t_coincide();
        arm(12'h9E1);
        @(negedge clk) cnv = 1'b1;
        @(posedge clk);
        repeat (N - 1) @(posedge clk);
        @(negedge clk) cnv = 1'b0;
        @(posedge clk) #1;
        chk("R4 fall on expiry edge: awake", slp, 0);
        chk("R4 fall on expiry edge: drive", oe, 1);
        chk("R4 fall on expiry edge: MSB", sdo, exp_word[DW-1]);
        read_word({6'b000000, 6'b000000}, "R4 coincident");
    endtask

    task automatic t_late();
        arm(12'h47F);
        @(negedge clk) cnv = 1'b1;
        @(posedge clk);
        repeat (N) @(posedge clk);
        #1;
        chk("R3 one cycle late: asleep", slp, 1);
        chk("R2 one cycle late: no drive", oe, 0);
        @(negedge clk) cnv = 1'b0;
        @(posedge clk) #1;
        chk("R3 late wake", slp, 0);
        chk("R3 late MSB", sdo, exp_word[DW-1]);
        read_word({6'b000000, 6'b000000}, "R3 late");
    endtask

    task automatic t_restart();
        arm(12'hB0B);
        @(negedge clk) cnv = 1'b1;
        @(negedge clk) cnv = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk) cnv = 1'b1;
        @(negedge clk) cnv = 1'b0;
        repeat (N - 22) @(posedge clk);
        #1;
        chk("R1 second rise did not end early", oe, 0);
        @(posedge clk) #1;
        chk("R1 second rise did not restart", oe, 1);
        chk("R1 MSB at original expiry", sdo, exp_word[DW-1]);
        read_word({6'b000000, 6'b000000}, "R1 restart");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk) #1;
        t_reset();
        t_basic();
        t_pairs();
        t_partial();
        t_sleep();
        t_coincide();
        t_late();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule